// File: doc/BRIEF.md
# Dual-Slope Buffered-Compare PWM Timer

This block is a 16-bit counter that counts up from zero to a programmable ceiling and then back down to zero. It drives two PWM pins, A and B, from two compare channels. Each pass through the ceiling and each pass through zero takes exactly one timer tick, so a full period is 2·N·TOP input clock cycles, where N is the prescaler ratio.

The compare values are written into holding registers. They move into the working registers only when the counter sits at zero. This keeps the rising and falling halves of every period the same length, even when software changes the duty cycle or the period while the timer runs. The ceiling comes either from a fixed register, which takes effect at once, or from the channel A compare value, which is buffered like the other compare values. When channel A sets the ceiling, pin A is held low and only pin B carries PWM.

Software programs the block through a simple write port. Address 0 holds the fixed ceiling, address 1 the channel A holding register, address 2 the channel B holding register, address 3 the control byte and address 4 the flag-clear register. The control byte has these fields: bits [1:0] are the output mode for A, bits [3:2] the output mode for B, bits [6:4] the prescaler select, and bit 7 selects channel A as the ceiling source. There are three sticky flags: a bottom flag, a channel A ceiling flag and a fixed-ceiling flag. Software clears a flag by writing a 1 to its bit at address 4: bit 0 for the bottom flag, bit 1 for the channel A ceiling flag, bit 2 for the fixed-ceiling flag.

Top module: `dspwm_timer`

## Requirements
- R1: After reset both PWM pins are low, all three flags are clear and the counter is stopped at zero, because the prescaler select resets to 0.
- R2: With a ceiling TOP of at least 1, the counter runs 0,1,…,TOP,TOP−1,…,1 and repeats. The bottom flag therefore rises once every 2·N·TOP clock cycles.
- R3: The prescaler select codes 1, 2, 3, 4 and 5 give N = 1, 8, 64, 256 and 1024. The codes 0, 6 and 7 stop the counter: no flag sets and no pin changes.
- R4: The compare values in use are loaded from the holding registers on the tick at zero, the same tick that sets the bottom flag. A holding-register write made during a period takes effect only in the next period.
- R5: When control bit 7 is 0, the fixed-ceiling register sets TOP directly. When it is 1, the buffered channel A compare value sets TOP.
- R6: When the counter turns at TOP, the channel A ceiling flag (bit 1) sets if control bit 7 is 1. Otherwise the fixed-ceiling flag (bit 2) sets. The bottom flag (bit 0) sets at zero.
- R7: In output mode 2 (non-inverted), a compare value C with 0<C<TOP makes the pin high for 2·N·C cycles per period. C=0 gives a constant low and C=TOP gives a constant high.
- R8: In output mode 3 (inverted), a compare value C with 0<C<TOP makes the pin high for 2·N·(TOP−C) cycles per period.
- R9: A compare value above TOP never matches, so the pin keeps the level it had.
- R10: Output modes 0 and 1 hold the pin low.
- R11: While channel A sets the ceiling, pin A stays low whatever its mode.
- R12: A flag stays set until a write of 1 to its bit at address 4. Writing 0 has no effect. A set event in the same cycle as a clear write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 ceiling, 1 compare A, 2 compare B, 3 control, 4 flag clear) |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | PWM pin of channel A |
| pwm_b | output | 1 | PWM pin of channel B |
| flag_bot | output | 1 | Sticky flag set when the counter is at zero |
| flag_topa | output | 1 | Sticky flag set at TOP when channel A sets the ceiling |
| flag_topf | output | 1 | Sticky flag set at TOP when the fixed register sets the ceiling |

## Verification
A register write lands on the rising edge after it is driven. A flag rises on the edge of the tick that causes it. A pin changes on the edge of the tick at which the counter equals the compare value. The bench therefore drives inputs and samples outputs on falling edges. It locks onto the first falling edge that shows the bottom flag set, clears that flag one edge later, and counts every sampled edge until the flag shows set again. That count is the period, and the sum of pin samples over the same window is the high time. A holding-register write made inside a measured window must not change that window's high time or period, only the following one.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_TOP  = 3'd0,
      REG_CMPA = 3'd1,
      REG_CMPB = 3'd2,
      REG_CTRL = 3'd3,
      REG_FCLR = 3'd4
   } reg_sel_e;

   typedef enum logic [1:0] {
      OM_OFF0   = 2'd0,
      OM_OFF1   = 2'd1,
      OM_NONINV = 2'd2,
      OM_INV    = 2'd3
   } out_mode_e;

   typedef struct packed {
      logic       src_a;
      logic [2:0] psel;
      logic [1:0] mode_b;
      logic [1:0] mode_a;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   // log2 of the prescaler ratio; 0 for codes that stop the timer
   function automatic logic [3:0] div_shift(input logic [2:0] sel);
      case (sel)
         3'd1:    div_shift = 4'd0;
         3'd2:    div_shift = 4'd3;
         3'd3:    div_shift = 4'd6;
         3'd4:    div_shift = 4'd8;
         3'd5:    div_shift = 4'd10;
         default: div_shift = 4'd0;
      endcase
   endfunction

   function automatic logic sel_runs(input logic [2:0] sel);
      sel_runs = (sel >= 3'd1) && (sel <= 3'd5);
   endfunction

endpackage

// File: rtl/dspwm_prescaler.sv
module dspwm_prescaler
   import dspwm_pkg::*;
#(
   parameter int PRE_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);

   if (PRE_W < 10) begin : g_bad_width
      $error("dspwm_prescaler: PRE_W must hold a divide of 1024");
   end

   logic [PRE_W-1:0] div_cnt;
   logic [PRE_W-1:0] lim;
   logic             run;

   assign run  = sel_runs(sel);
   assign lim  = (PRE_W'(1) << div_shift(sel)) - PRE_W'(1);
   assign tick = run && (div_cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_cnt <= '0;
      else if (!run)     div_cnt <= '0;
      else if (tick)     div_cnt <= '0;
      else               div_cnt <= div_cnt + PRE_W'(1);
   end

   AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_runs(sel) |-> !tick); // R3

endmodule

// File: rtl/dspwm_updown.sv
module dspwm_updown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             src_a,
   input  logic [CNT_W-1:0] top_fix,
   input  logic [CNT_W-1:0] buf_a,
   input  logic [CNT_W-1:0] buf_b,
   output logic [CNT_W-1:0] cnt,
   output logic             up_phase,
   output logic             bot_evt,
   output logic             top_evt,
   output logic [CNT_W-1:0] use_a,
   output logic [CNT_W-1:0] use_b
);

   if (CNT_W < 2) begin : g_bad_width
      $error("dspwm_updown: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] act_a, act_b, top_eff;
   logic             dir_up, at_bot;

   assign at_bot   = (cnt == '0);
   // at zero the freshly loaded values already govern this tick
   assign use_a    = at_bot ? buf_a : act_a;
   assign use_b    = at_bot ? buf_b : act_b;
   assign top_eff  = src_a ? use_a : top_fix;
   assign bot_evt  = tick && at_bot;
   assign top_evt  = tick && !at_bot && dir_up && (cnt >= top_eff);
   // a match at zero counts as rising, a match at the turn as falling
   assign up_phase = at_bot || (dir_up && (cnt < top_eff));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
         act_a  <= '0;
         act_b  <= '0;
      end else if (tick) begin
         if (at_bot) begin
            act_a  <= buf_a;
            act_b  <= buf_b;
            dir_up <= 1'b1;
            cnt    <= (top_eff == '0) ? '0 : CNT_W'(1);
         end else if (dir_up && (cnt >= top_eff)) begin
            dir_up <= 1'b0;
            cnt    <= cnt - CNT_W'(1);
         end else if (dir_up) begin
            cnt    <= cnt + CNT_W'(1);
         end else begin
            cnt    <= cnt - CNT_W'(1);
         end
      end
   end

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt)); // R3
   AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      top_evt |=> (!dir_up && cnt == $past(cnt) - CNT_W'(1))); // R2
   AST_RISE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bot_evt && top_eff != '0) |=> (dir_up && cnt == CNT_W'(1))); // R2
   AST_LOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bot_evt |=> (act_b == $past(buf_b))); // R4
   AST_ACTIVE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !bot_evt |=> ($stable(act_a) && $stable(act_b))); // R4

endmodule

// File: rtl/dspwm_channel.sv
module dspwm_channel
   import dspwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             up_phase,
   input  logic [1:0]       mode,
   input  logic             pin_en,
   output logic             pin
);

   logic level_q, hit;

   assign hit = tick && (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else if (hit) begin
         case (out_mode_e'(mode))
            OM_NONINV: level_q <= !up_phase;
            OM_INV:    level_q <= up_phase;
            default:   level_q <= level_q;
         endcase
      end
   end

   assign pin = pin_en && mode[1] && level_q;

   AST_LEVEL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(level_q)); // R9
   AST_NONINV_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && up_phase && mode == 2'd2) |=> !level_q); // R7
   AST_INV_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && up_phase && mode == 2'd3) |=> level_q); // R8

endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
   import dspwm_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [15:0] wr_data,
   output logic        pwm_a,
   output logic        pwm_b,
   output logic        flag_bot,
   output logic        flag_topa,
   output logic        flag_topf
);

   localparam int NCH = 2;

   if (CNT_W != 16) begin : g_bad_cnt
      $error("dspwm_timer: the write port carries 16-bit values");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] top_fix, buf_a, buf_b;
   logic [CNT_W-1:0] cnt, use_a, use_b;
   logic             tick, up_phase, bot_evt, top_evt;
   logic [2:0]       clr;
   logic             unused_ctrl_hi;

   assign unused_ctrl_hi = ^wr_data[15:CTRL_W];
   assign clr = (wr_en && wr_addr == REG_FCLR) ? wr_data[2:0] : 3'b000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         top_fix <= '0;
         buf_a   <= '0;
         buf_b   <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_addr))
            REG_TOP:  top_fix <= wr_data;
            REG_CMPA: buf_a   <= wr_data;
            REG_CMPB: buf_b   <= wr_data;
            REG_CTRL: ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_bot  <= 1'b0;
         flag_topa <= 1'b0;
         flag_topf <= 1'b0;
      end else begin
         flag_bot  <= (flag_bot  && !clr[0]) || bot_evt;
         flag_topa <= (flag_topa && !clr[1]) || (top_evt && ctrl.src_a);
         flag_topf <= (flag_topf && !clr[2]) || (top_evt && !ctrl.src_a);
      end
   end

   dspwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(ctrl.psel), .tick(tick)
   );

   dspwm_updown #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .src_a(ctrl.src_a),
      .top_fix(top_fix), .buf_a(buf_a), .buf_b(buf_b), .cnt(cnt),
      .up_phase(up_phase), .bot_evt(bot_evt), .top_evt(top_evt),
      .use_a(use_a), .use_b(use_b)
   );

   logic [CNT_W-1:0] ch_cmp  [NCH];
   logic [1:0]       ch_mode [NCH];
   logic             ch_en   [NCH];
   logic             ch_pin  [NCH];

   assign ch_cmp[0]  = use_a;
   assign ch_cmp[1]  = use_b;
   assign ch_mode[0] = ctrl.mode_a;
   assign ch_mode[1] = ctrl.mode_b;
   assign ch_en[0]   = !ctrl.src_a;
   assign ch_en[1]   = 1'b1;

   for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
      dspwm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt),
         .cmp(ch_cmp[gi]), .up_phase(up_phase), .mode(ch_mode[gi]),
         .pin_en(ch_en[gi]), .pin(ch_pin[gi])
      );
   end

   assign pwm_a = ch_pin[0];
   assign pwm_b = ch_pin[1];

   AST_BOT_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      bot_evt |=> flag_bot); // R6
   AST_TOPA_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (top_evt && ctrl.src_a) |=> flag_topa); // R6
   AST_BOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_bot && !clr[0]) |=> flag_bot); // R12
   AST_TOPF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_topf && !clr[2]) |=> flag_topf); // R12
   AST_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctrl.src_a) && ctrl.src_a) |-> !pwm_a); // R11

endmodule

// File: tb/dspwm_timer_test.sv
module dspwm_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;

   // stimulus table: ceiling, compare B, mode B, prescaler select, expected high cycles
   localparam int V_TOP  [NV] = '{10, 10,   7, 12, 12, 12, 12, 12,   3,    5,    2};
   localparam int V_CMP  [NV] = '{ 4,  4,   3,  0, 17, 12, 20,  5,   1,    2,    1};
   localparam int V_MODE [NV] = '{ 2,  3,   2,  2,  2,  2,  2,  1,   3,    2,    2};
   localparam int V_SEL  [NV] = '{ 1,  1,   2,  1,  1,  1,  1,  1,   3,    4,    5};
   localparam int V_HIGH [NV] = '{ 8, 12,  48,  0,  0, 24, 24,  0, 256, 1024, 2048};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        pwm_a, pwm_b, flag_bot, flag_topa, flag_topf;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dspwm_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b),
      .flag_bot(flag_bot), .flag_topa(flag_topa), .flag_topf(flag_topf)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_addr = a;
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   function automatic logic [15:0] ctrl_word(input int ma, input int mb,
                                             input int sel, input bit src);
      ctrl_word = 16'((ma & 3) | ((mb & 3) << 2) | ((sel & 7) << 4) | (int'(src) << 7));
   endfunction

   // Locks onto a zero tick, then counts one full period of samples.
   task automatic measure(input bit pre, input logic [2:0] pa, input logic [15:0] pd,
                          output int per, output int hb, output int ha);
      wr(3'd4, 16'h0001);
      while (!flag_bot) @(negedge clk);
      hb = int'(pwm_b); ha = int'(pwm_a); per = 1;
      if (pre) begin
         wr(pa, pd);
         hb += int'(pwm_b); ha += int'(pwm_a); per++;
      end
      wr(3'd4, 16'h0001);
      while (!flag_bot && per < 20000) begin
         hb += int'(pwm_b); ha += int'(pwm_a); per++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int per, hb, ha, n, p0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 pwm_a", int'(pwm_a), 0);
      chk("R1 pwm_b", int'(pwm_b), 0);
      chk("R1 flags", int'({flag_bot, flag_topa, flag_topf}), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 stopped after reset", int'({flag_bot, flag_topf, pwm_b}), 0);

      wr(3'd4, 16'h0007);
      for (int i = 0; i < NV; i++) begin
         n = 1 << (V_SEL[i] == 1 ? 0 : V_SEL[i] == 2 ? 3 : V_SEL[i] == 3 ? 6 :
                   V_SEL[i] == 4 ? 8 : 10);
         wr(3'd3, ctrl_word(0, V_MODE[i], V_SEL[i], 1'b0));
         wr(3'd0, 16'(V_TOP[i]));
         wr(3'd2, 16'(V_CMP[i]));
         measure(1'b0, 3'd0, 16'h0, per, hb, ha);
         measure(1'b0, 3'd0, 16'h0, per, hb, ha);
         chk($sformatf("R2 R3 period vec%0d", i), per, 2 * n * V_TOP[i]);
         chk($sformatf("R7 R8 R9 R10 high vec%0d", i), hb, V_HIGH[i]);
      end
      // R6: fixed ceiling raised the fixed-ceiling flag only
      chk("R6 topf set", int'(flag_topf), 1);
      chk("R6 topa clear", int'(flag_topa), 0);

      // R4: compare B write mid-period acts one period later
      wr(3'd3, ctrl_word(0, 2, 1, 1'b0));
      wr(3'd0, 16'd10);
      wr(3'd2, 16'd4);
      measure(1'b0, 3'd0, 16'h0, per, hb, ha);
      measure(1'b1, 3'd2, 16'd8, per, hb, ha);
      chk("R4 B old compare kept", hb, 8);
      measure(1'b0, 3'd0, 16'h0, per, hb, ha);
      chk("R4 B new compare", hb, 16);

      // R5 R11: channel A sets the ceiling, buffered
      wr(3'd1, 16'd20);
      wr(3'd2, 16'd5);
      wr(3'd3, ctrl_word(2, 2, 1, 1'b1));
      wr(3'd4, 16'h0007);
      measure(1'b0, 3'd0, 16'h0, per, hb, ha);
      measure(1'b0, 3'd0, 16'h0, per, hb, ha);
      chk("R5 period from A", per, 40);
      chk("R7 B high with A ceiling", hb, 10);
      chk("R11 pin A silent", ha, 0);
      chk("R6 topa set", int'(flag_topa), 1);
      chk("R6 topf clear", int'(flag_topf), 0);
      measure(1'b1, 3'd1, 16'd30, per, hb, ha);
      chk("R4 R5 ceiling change deferred", per, 40);
      measure(1'b0, 3'd0, 16'h0, per, hb, ha);
      chk("R4 R5 new ceiling", per, 60);
      chk("R11 pin A silent again", ha, 0);

      // R3: stop codes
      for (int s = 0; s < 8; s += 6) begin
         wr(3'd3, ctrl_word(0, 2, s, 1'b0));
         wr(3'd4, 16'h0007);
         p0 = int'(pwm_b);
         n = 0;
         for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (pwm_b !== p0[0] || flag_bot || flag_topf) n++;
         end
         chk($sformatf("R3 stopped by code %0d", s), n, 0);
      end

      // R12: sticky, write-one-to-clear
      wr(3'd0, 16'd10);
      wr(3'd3, ctrl_word(0, 2, 1, 1'b0));
      repeat (50) @(negedge clk);
      wr(3'd3, ctrl_word(0, 2, 0, 1'b0));
      chk("R12 both set", int'({flag_bot, flag_topf}), 3);
      wr(3'd4, 16'h0004);
      chk("R12 clear only fixed-ceiling flag", int'({flag_bot, flag_topf}), 2);
      wr(3'd4, 16'h0000);
      chk("R12 zero write ignored", int'(flag_bot), 1);
      wr(3'd4, 16'h0001);
      chk("R12 bottom flag cleared", int'(flag_bot), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule